// File: doc/BRIEF.md
# Gigabit PCS Receive Frame Deframer

This block sits between a 1000BASE-X code-group decoder and a byte-wide MAC receive interface. Each clock it takes one decoded 8-bit code-group with a control flag and a decode-error flag. It produces a byte stream with a data-valid and a receive-error qualifier. A frame is accepted only when a complete idle (the comma code-group 0xBC with its control flag set, then one data code-group) is followed immediately by the start delimiter. The start delimiter is handed to the MAC as a preamble byte. Data code-groups are passed through until the terminate delimiter.

The termination rule needs the terminate delimiter to be followed by a carrier-extend code-group, and that is only known after the last data byte. The block therefore looks two code-groups ahead. Any termination fault is flagged on the last byte while data-valid is still high. Activity that does not begin with idle then start is discarded. The block then ignores the line until a full idle is seen again.

Top module: `pcs_rx_deframer`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) forces `mac_rx_dv` and `mac_rx_er` low and `mac_rxd` to 0x00. After reset the block waits for a full idle before it will accept a start.
- R2: `mac_rx_dv` rises only for a start code-group (0xFB, control flag set, no decode error) whose two predecessors were 0xBC with the control flag set and then a valid data code-group. That start is delivered as byte 0x55 with `mac_rx_dv` high and `mac_rx_er` low.
- R3: Valid data code-groups inside a frame appear on `mac_rxd` unchanged, with `mac_rx_dv` high. The output follows the input by three rising edges.
- R4: A terminate code-group (0xFD, control flag set) ends the frame. It produces no data-valid cycle. Whenever `mac_rx_dv` is low, `mac_rxd` is 0x00.
- R5: Any code-group other than the start that follows a completed idle, and any start that does not directly follow a completed idle, produces no data-valid. The block then stays quiet until a new complete idle has passed.
- R6: A code-group with its decode-error flag set inside a frame is output with `mac_rx_dv` and `mac_rx_er` both high, and the frame continues.
- R7: When the data byte just before a terminate code-group is not followed by the sequence terminate then carrier-extend (0xF7, control flag set), that last byte is output with `mac_rx_er` high.
- R8: A control code-group other than terminate inside a frame (for example 0xBC or 0xFB) is output as its byte with `mac_rx_dv` and `mac_rx_er` high. The frame then ends and the block waits for idle.
- R9: `mac_rx_er` is never high while `mac_rx_dv` is low. Code-groups with decode errors outside a frame have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock, one code-group per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| cg_byte | input | 8 | Decoded code-group value |
| cg_is_ctrl | input | 1 | Code-group is a control (K) character |
| cg_bad | input | 1 | Decoder reported an invalid code-group |
| mac_rxd | output | 8 | Receive byte to the MAC |
| mac_rx_dv | output | 1 | Receive data valid |
| mac_rx_er | output | 1 | Receive error, only while data valid is high |

## Verification
A state register stuck in the frame state would show up within three edges: idle bytes would appear with data-valid high and the error flag raised on the comma. A state that never leaves the ready state would accept a start that follows an aborted run of data, so a frame would appear where the bench expects silence. A lookahead tap that is off by one stage moves the termination error to the wrong byte or drops it. The vector table compares every output cycle, so such a shift shows as a miscompare on the byte next to the terminate delimiter.

// File: rtl/pcs_rx_pkg.sv
// Package: shared code-group type, delimiter values and classifiers for
// the PCS receive deframer. Assumes code-groups arrive already decoded.
package pcs_rx_pkg;

    localparam int CG_W = 8;
    // Lookahead depth fixed by the termination rule: terminate then extend.
    localparam int LOOK = 2;

    localparam logic [CG_W-1:0] CG_START  = 8'hFB;
    localparam logic [CG_W-1:0] CG_TERM   = 8'hFD;
    localparam logic [CG_W-1:0] CG_EXTEND = 8'hF7;
    localparam logic [CG_W-1:0] CG_COMMA  = 8'hBC;
    localparam logic [CG_W-1:0] PREAMBLE  = 8'h55;

    typedef struct packed {
        logic [CG_W-1:0] val;
        logic            ctrl;
        logic            bad;
    } cg_t;

    typedef enum logic [1:0] {
        ST_QUIET = 2'd0,
        ST_READY = 2'd1,
        ST_FRAME = 2'd2
    } rx_state_e;

    function automatic logic is_data(input cg_t c);
        return !c.bad && !c.ctrl;
    endfunction

    function automatic logic is_ctl(input cg_t c, input logic [CG_W-1:0] code);
        return !c.bad && c.ctrl && (c.val == code);
    endfunction

endpackage

// File: rtl/pcs_rx_lookahead.sv
// Module: delay line holding the most recent code-groups so that the
// framing logic can see LOOK code-groups beyond the one it is emitting.
// taps[0] is the live input, taps[k] is the input delayed by k cycles.
module pcs_rx_lookahead
    import pcs_rx_pkg::*;
#(
    parameter int DEPTH = LOOK
) (
    input  logic clk,
    input  logic rst_n,
    input  cg_t  cg_in,
    output cg_t  taps [DEPTH+1]
);

    cg_t stage [DEPTH];

    assign taps[0] = cg_in;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture the live code-group; reset loads a neutral data value.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= '0;
                else        stage[g] <= cg_in;
            end
        end else begin : g_next
            // Shift the previous stage one step further back.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= '0;
                else        stage[g] <= stage[g-1];
            end
        end
        assign taps[g+1] = stage[g];
    end

endmodule

// File: rtl/pcs_rx_frame_fsm.sv
// Module: framing state machine. Decides data-valid, error and output byte
// for the oldest buffered code-group (cur), using the two newer ones
// (nxt1, nxt2) to judge the termination. Outputs are registered.
// Assumes one code-group per clock with no gaps.
module pcs_rx_frame_fsm
    import pcs_rx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  cg_t             cur,
    input  cg_t             nxt1,
    input  cg_t             nxt2,
    output logic [CG_W-1:0] rxd,
    output logic            rx_dv,
    output logic            rx_er
);

    rx_state_e       state, state_n;
    logic            comma_prev;
    logic            idle_done;
    logic            bad_end;
    logic [CG_W-1:0] rxd_n;
    logic            dv_n, er_n;

    // Remember whether the previous code-group was a valid comma.
    always_ff @(posedge clk) begin
        if (!rst_n) comma_prev <= 1'b0;
        else        comma_prev <= is_ctl(cur, CG_COMMA);
    end

    assign idle_done = comma_prev && is_data(cur);
    assign bad_end   = is_ctl(nxt1, CG_TERM) && !is_ctl(nxt2, CG_EXTEND);

    // Next-state and next-output decision for the current code-group.
    always_comb begin
        state_n = state;
        rxd_n   = '0;
        dv_n    = 1'b0;
        er_n    = 1'b0;
        if (state == ST_FRAME) begin
            if (is_ctl(cur, CG_TERM)) begin
                state_n = ST_QUIET;
            end else if (cur.bad || !cur.ctrl) begin
                dv_n  = 1'b1;
                rxd_n = cur.val;
                er_n  = cur.bad || bad_end;
            end else begin
                dv_n    = 1'b1;
                er_n    = 1'b1;
                rxd_n   = cur.val;
                state_n = ST_QUIET;
            end
        end else if (state == ST_READY && is_ctl(cur, CG_START)) begin
            dv_n    = 1'b1;
            rxd_n   = PREAMBLE;
            state_n = ST_FRAME;
        end else if (idle_done) begin
            state_n = ST_READY;
        end else begin
            state_n = ST_QUIET;
        end
    end

    // Register state and outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_QUIET;
            rxd   <= '0;
            rx_dv <= 1'b0;
            rx_er <= 1'b0;
        end else begin
            state <= state_n;
            rxd   <= rxd_n;
            rx_dv <= dv_n;
            rx_er <= er_n;
        end
    end

endmodule

// File: rtl/pcs_rx_deframer.sv
// Module: top of the PCS receive deframer. Packs the decoded code-group
// inputs, buffers LOOK of them, and drives the MAC-side byte stream.
// Latency from input code-group to output byte is LOOK+1 rising edges.
module pcs_rx_deframer
    import pcs_rx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CG_W-1:0] cg_byte,
    input  logic            cg_is_ctrl,
    input  logic            cg_bad,
    output logic [CG_W-1:0] mac_rxd,
    output logic            mac_rx_dv,
    output logic            mac_rx_er
);

    cg_t in_cg;
    cg_t taps [LOOK+1];

    assign in_cg = '{val: cg_byte, ctrl: cg_is_ctrl, bad: cg_bad};

    pcs_rx_lookahead #(.DEPTH(LOOK)) u_look (
        .clk   (clk),
        .rst_n (rst_n),
        .cg_in (in_cg),
        .taps  (taps)
    );

    pcs_rx_frame_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (taps[LOOK]),
        .nxt1  (taps[LOOK-1]),
        .nxt2  (taps[LOOK-2]),
        .rxd   (mac_rxd),
        .rx_dv (mac_rx_dv),
        .rx_er (mac_rx_er)
    );

endmodule

// File: rtl/pcs_rx_deframer_chk.sv
// Checker: port-level properties of the deframer, bound to every instance.
module pcs_rx_deframer_chk
    import pcs_rx_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [CG_W-1:0] cg_byte,
    input logic            cg_is_ctrl,
    input logic            cg_bad,
    input logic [CG_W-1:0] mac_rxd,
    input logic            mac_rx_dv,
    input logic            mac_rx_er
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!mac_rx_dv && !mac_rx_er && mac_rxd == '0));

    assert_start_after_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mac_rx_dv) |-> (mac_rxd == PREAMBLE
            && $past(cg_is_ctrl, 3) && !$past(cg_bad, 3) && $past(cg_byte, 3) == CG_START
            && $past(cg_is_ctrl, 5) && $past(cg_byte, 5) == CG_COMMA));

    assert_quiet_byte_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mac_rx_dv |-> mac_rxd == '0);

    assert_term_not_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cg_is_ctrl, 3) && !$past(cg_bad, 3) && $past(cg_byte, 3) == CG_TERM)
            |-> !mac_rx_dv);

    assert_bad_sets_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_rx_dv && $past(cg_bad, 3)) |-> mac_rx_er);

    assert_error_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mac_rx_er |-> mac_rx_dv);

endmodule

bind pcs_rx_deframer pcs_rx_deframer_chk u_chk (.*);

// File: tb/pcs_rx_deframer_bench.sv
// Bench: walks a vector table of code-groups and expected outputs, then
// runs directed reset and recovery cases.
module pcs_rx_deframer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cg_byte = 8'h00;
    logic       cg_is_ctrl = 1'b0;
    logic       cg_bad = 1'b0;
    logic [7:0] mac_rxd;
    logic       mac_rx_dv;
    logic       mac_rx_er;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    pcs_rx_deframer u_pcs_rx_deframer (.*);

    always #10 clk = ~clk;

    // {req[3:0], ctrl, bad, byte[7:0], dv, er, rxd[7:0]}
    function automatic logic [23:0] v(input logic [3:0] r, input logic c, input logic b,
                                      input logic [7:0] d, input logic dv, input logic er,
                                      input logic [7:0] q);
        return {r, c, b, d, dv, er, q};
    endfunction

    localparam int NV = 60;
    localparam logic [23:0] TBL [NV] = '{
        v(2,1,0,8'hBC,0,0,8'h00), v(2,0,0,8'h50,0,0,8'h00),   // R2 idle
        v(2,1,0,8'hFB,1,0,8'h55),                             // R2 start -> preamble
        v(3,0,0,8'h55,1,0,8'h55), v(3,0,0,8'hD5,1,0,8'hD5),   // R3
        v(3,0,0,8'hA1,1,0,8'hA1), v(7,0,0,8'h3C,1,0,8'h3C),   // R7 clean end
        v(4,1,0,8'hFD,0,0,8'h00), v(4,1,0,8'hF7,0,0,8'h00),   // R4
        v(4,1,0,8'hF7,0,0,8'h00),
        v(2,1,0,8'hBC,0,0,8'h00), v(2,0,0,8'h50,0,0,8'h00),
        v(2,1,0,8'hFB,1,0,8'h55),
        v(6,0,1,8'h77,1,1,8'h77), v(6,0,0,8'h12,1,0,8'h12),   // R6
        v(4,1,0,8'hFD,0,0,8'h00), v(4,1,0,8'hF7,0,0,8'h00),
        v(2,1,0,8'hBC,0,0,8'h00), v(2,0,0,8'h50,0,0,8'h00),
        v(2,1,0,8'hFB,1,0,8'h55),
        v(7,0,0,8'h9A,1,1,8'h9A), v(7,1,0,8'hFD,0,0,8'h00),   // R7 no extend
        v(2,1,0,8'hBC,0,0,8'h00), v(2,0,0,8'h50,0,0,8'h00),
        v(2,1,0,8'hFB,1,0,8'h55),
        v(3,0,0,8'h44,1,0,8'h44), v(8,1,0,8'hBC,1,1,8'hBC),   // R8 comma
        v(8,0,0,8'h50,0,0,8'h00), v(8,1,0,8'hFB,1,0,8'h55),
        v(4,1,0,8'hFD,0,0,8'h00), v(4,1,0,8'hF7,0,0,8'h00),
        v(4,1,0,8'hF7,0,0,8'h00),
        v(5,1,0,8'hBC,0,0,8'h00), v(5,0,0,8'h50,0,0,8'h00),
        v(5,0,0,8'h11,0,0,8'h00), v(5,1,0,8'hFB,0,0,8'h00),   // R5 abort
        v(5,0,0,8'h22,0,0,8'h00), v(5,1,0,8'hFD,0,0,8'h00),
        v(5,1,0,8'hF7,0,0,8'h00),
        v(5,1,0,8'hBC,0,0,8'h00), v(5,0,0,8'h50,0,0,8'h00),
        v(5,1,0,8'hFB,1,0,8'h55), v(3,0,0,8'h66,1,0,8'h66),
        v(4,1,0,8'hFD,0,0,8'h00), v(4,1,0,8'hF7,0,0,8'h00),
        v(4,1,0,8'hF7,0,0,8'h00),
        v(9,0,1,8'hFF,0,0,8'h00),                             // R9 bad outside
        v(2,1,0,8'hBC,0,0,8'h00), v(2,0,0,8'h50,0,0,8'h00),
        v(2,1,0,8'hFB,1,0,8'h55), v(3,0,0,8'h33,1,0,8'h33),
        v(8,1,0,8'hFB,1,1,8'hFB),                             // R8 start inside
        v(8,1,0,8'hBC,0,0,8'h00), v(8,0,0,8'h50,0,0,8'h00),
        v(8,1,0,8'hFB,1,0,8'h55),
        v(4,1,0,8'hFD,0,0,8'h00), v(4,1,0,8'hF7,0,0,8'h00),
        v(4,1,0,8'hF7,0,0,8'h00),
        v(2,1,0,8'hBC,0,0,8'h00), v(2,0,0,8'h50,0,0,8'h00)
    };

    logic [23:0] pend [2];
    logic        pend_ok [2];

    task automatic compare(input logic [23:0] e);
        n_vec++;
        if (mac_rx_dv !== e[9] || mac_rx_er !== e[8] || mac_rxd !== e[7:0]) begin
            n_bad++;
            $display("FAIL R%0d: got dv=%b er=%b rxd=%h, expected dv=%b er=%b rxd=%h",
                     e[23:20], mac_rx_dv, mac_rx_er, mac_rxd, e[9], e[8], e[7:0]);
        end
    endtask

    // Drive one code-group; compare the output due from two steps earlier.
    task automatic step(input logic [23:0] e, input bit chk);
        cg_is_ctrl = e[19];
        cg_bad     = e[18];
        cg_byte    = e[17:10];
        @(posedge clk);
        @(negedge clk);
        if (pend_ok[1]) compare(pend[1]);
        pend[1]    = pend[0];
        pend_ok[1] = pend_ok[0];
        pend[0]    = e;
        pend_ok[0] = chk;
    endtask

    task automatic flush();
        pend_ok[0] = 1'b0;
        pend_ok[1] = 1'b0;
    endtask

    initial begin
        flush();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        compare(v(1,0,0,8'h00,0,0,8'h00));                   // R1 reset state
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) step(TBL[i], 1'b1);
        step(v(2,1,0,8'hBC,0,0,8'h00), 1'b0);
        step(v(2,0,0,8'h50,0,0,8'h00), 1'b0);

        // R1: reset in the middle of a frame clears outputs.
        step(v(1,1,0,8'hFB,1,0,8'h55), 1'b0);
        step(v(1,0,0,8'hAB,1,0,8'hAB), 1'b0);
        step(v(1,0,0,8'hCD,1,0,8'hCD), 1'b0);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        compare(v(1,0,0,8'h00,0,0,8'h00));
        rst_n = 1'b1;
        flush();

        // R1/R5: after reset a start without a preceding idle is dropped.
        step(v(5,1,0,8'hFB,0,0,8'h00), 1'b1);
        step(v(5,0,0,8'hAA,0,0,8'h00), 1'b1);
        step(v(5,1,0,8'hFD,0,0,8'h00), 1'b1);
        step(v(5,1,0,8'hF7,0,0,8'h00), 1'b1);
        // R2/R3: recovery with a proper idle then start.
        step(v(2,1,0,8'hBC,0,0,8'h00), 1'b1);
        step(v(2,0,0,8'h50,0,0,8'h00), 1'b1);
        step(v(2,1,0,8'hFB,1,0,8'h55), 1'b1);
        step(v(3,0,0,8'hC3,1,0,8'hC3), 1'b1);
        step(v(4,1,0,8'hFD,0,0,8'h00), 1'b1);
        step(v(4,1,0,8'hF7,0,0,8'h00), 1'b1);
        step(v(2,1,0,8'hBC,0,0,8'h00), 1'b0);
        step(v(2,0,0,8'h50,0,0,8'h00), 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule